// File: doc/BRIEF.md
# Three-Bus General Purpose Register File

This block holds the general purpose registers of a small processor datapath that has three internal buses. Two of the buses carry operands towards the ALU. The third carries the ALU result back into the registers. Any register can be placed on either operand bus, each under its own enable and its own 3-bit selector. A single write port loads the result bus into one register. That register is chosen by a destination code, which passes through an enabled one-hot decoder.

Entry 0 is a constant zero. A destination code of zero therefore means "write nothing", and the control unit can use it for steps that must not change any register. The control unit also needs the literal values +1 and -1, for example to step the program counter. The block supplies both constants as extra sources on each operand bus, and each constant has its own enable on each bus.

When more than one source is enabled on an operand bus, the bus shows the bitwise OR of those sources, and a conflict flag for that bus goes high. This makes a control-word error visible in the same cycle it happens.

Top module: `tribus_regfile`

## Requirements
- R1: Selecting code 0 on either operand bus, with its register enable high and no constant enabled, yields all zeros.
- R2: With `a_reg_en` high and no constant enabled on bus A, `bus_a` equals the register selected by `a_sel`, for each of the eight codes.
- R3: With `b_reg_en` high and no constant enabled on bus B, `bus_b` equals the register selected by `b_sel`, independently of what bus A selects.
- R4: When `wr_en` is high and `wr_sel` is nonzero, the register numbered `wr_sel` takes `wr_data` at the rising clock edge, and no other register changes.
- R5: When `wr_en` is low, no register changes, whatever `wr_sel` and `wr_data` hold.
- R6: A read of a register in the same cycle as a write to it returns the old value. The new value appears only after the edge.
- R7: An operand bus with none of its three sources enabled reads all zeros.
- R8: `one_a_en` / `one_b_en` drive the value 1 onto their bus, and `neg_a_en` / `neg_b_en` drive all ones (the value -1).
- R9: When two or more sources are enabled on a bus, that bus shows the bitwise OR of the enabled sources and its conflict flag is high. With zero or one source enabled, the flag is low.
- R10: An active-low asynchronous reset clears registers 1 to 7 to zero.
- R11: A write with `wr_en` high and `wr_sel` equal to 0 changes no register, and register 0 still reads zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_sel | input | 3 | Register selected for bus A |
| a_reg_en | input | 1 | Puts the selected register on bus A |
| one_a_en | input | 1 | Puts constant +1 on bus A |
| neg_a_en | input | 1 | Puts constant -1 on bus A |
| b_sel | input | 3 | Register selected for bus B |
| b_reg_en | input | 1 | Puts the selected register on bus B |
| one_b_en | input | 1 | Puts constant +1 on bus B |
| neg_b_en | input | 1 | Puts constant -1 on bus B |
| wr_sel | input | 3 | Destination register code; 0 means no write |
| wr_en | input | 1 | Enables the destination decoder |
| wr_data | input | 32 | Result bus value to be stored |
| bus_a | output | 32 | Operand bus A |
| bus_b | output | 32 | Operand bus B |
| a_conflict | output | 1 | More than one source enabled on bus A |
| b_conflict | output | 1 | More than one source enabled on bus B |

## Verification
The bench builds the block with its default parameters: 32-bit data and eight registers. This keeps the selector space small enough to read all 64 pairs of (A, B) codes against a model held in the bench, and to try all eight enable combinations on each bus. It covers writes to every destination code, including the null code 0 and writes with the enable low. It also checks a read and a write to the same register in one cycle, and a reset applied in the middle of a run.

// File: rtl/tribus_regfile.sv
module tribus_regfile #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  a_sel,
  input  logic              a_reg_en,
  input  logic              one_a_en,
  input  logic              neg_a_en,
  input  logic [SEL_W-1:0]  b_sel,
  input  logic              b_reg_en,
  input  logic              one_b_en,
  input  logic              neg_b_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] bus_a,
  output logic [DATA_W-1:0] bus_b,
  output logic              a_conflict,
  output logic              b_conflict
);

  localparam logic [DATA_W-1:0] K_ONE = DATA_W'(1);
  localparam logic [DATA_W-1:0] K_NEG = '1;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [NUM_REGS-1:0]             wr_hit;

  always_comb begin
    wr_hit = '0;
    if (wr_en) wr_hit[wr_sel] = 1'b1;
    wr_hit[0] = 1'b0;
  end

  assign regs_q[0] = '0;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         regs_q[i] <= '0;
      else if (wr_hit[i]) regs_q[i] <= wr_data;
    end
  end

  logic [DATA_W-1:0] a_reg_val, b_reg_val;
  assign a_reg_val = a_reg_en ? regs_q[a_sel] : '0;
  assign b_reg_val = b_reg_en ? regs_q[b_sel] : '0;

  assign bus_a = a_reg_val | (one_a_en ? K_ONE : '0) | (neg_a_en ? K_NEG : '0);
  assign bus_b = b_reg_val | (one_b_en ? K_ONE : '0) | (neg_b_en ? K_NEG : '0);

  assign a_conflict = (2'(a_reg_en) + 2'(one_a_en) + 2'(neg_a_en)) > 2'd1;
  assign b_conflict = (2'(b_reg_en) + 2'(one_b_en) + 2'(neg_b_en)) > 2'd1;

endmodule

// File: rtl/tribus_regfile_chk.sv
module tribus_regfile_chk #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int SEL_W    = $clog2(NUM_REGS)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [SEL_W-1:0]                a_sel,
  input logic                            a_reg_en,
  input logic                            one_a_en,
  input logic                            neg_a_en,
  input logic                            b_reg_en,
  input logic                            one_b_en,
  input logic                            neg_b_en,
  input logic [SEL_W-1:0]                wr_sel,
  input logic                            wr_en,
  input logic [DATA_W-1:0]               wr_data,
  input logic [DATA_W-1:0]               bus_a,
  input logic [DATA_W-1:0]               bus_b,
  input logic                            a_conflict,
  input logic                            b_conflict,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);

  AST_ZERO_ENTRY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (a_reg_en && a_sel == '0 && !one_a_en && !neg_a_en) |-> bus_a == '0); // R1

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != '0) |=> regs_q[$past(wr_sel)] == $past(wr_data)); // R4

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q)); // R5

  AST_NULL_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == '0) |=> $stable(regs_q)); // R11

  AST_IDLE_BUS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_reg_en && !one_a_en && !neg_a_en) |-> bus_a == '0); // R7

  AST_IDLE_BUS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_reg_en && !one_b_en && !neg_b_en) |-> bus_b == '0); // R7

  AST_CONFLICT_A: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({a_reg_en, one_a_en, neg_a_en}) > 1) == a_conflict); // R9

  AST_CONFLICT_B: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({b_reg_en, one_b_en, neg_b_en}) > 1) == b_conflict); // R9

  AST_NEG_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    neg_a_en |-> bus_a == '1); // R8

endmodule

bind tribus_regfile tribus_regfile_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) chk_i (
  .clk(clk), .rst_n(rst_n), .a_sel(a_sel), .a_reg_en(a_reg_en), .one_a_en(one_a_en),
  .neg_a_en(neg_a_en), .b_reg_en(b_reg_en), .one_b_en(one_b_en), .neg_b_en(neg_b_en),
  .wr_sel(wr_sel), .wr_en(wr_en), .wr_data(wr_data), .bus_a(bus_a), .bus_b(bus_b),
  .a_conflict(a_conflict), .b_conflict(b_conflict), .regs_q(regs_q)
);

// File: tb/tribus_regfile_tb.sv
module tribus_regfile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] a_sel = '0, b_sel = '0, wr_sel = '0;
  logic a_reg_en = 0, one_a_en = 0, neg_a_en = 0;
  logic b_reg_en = 0, one_b_en = 0, neg_b_en = 0;
  logic wr_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] bus_a, bus_b;
  logic a_conflict, b_conflict;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  tribus_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_sel(a_sel), .a_reg_en(a_reg_en), .one_a_en(one_a_en), .neg_a_en(neg_a_en),
    .b_sel(b_sel), .b_reg_en(b_reg_en), .one_b_en(one_b_en), .neg_b_en(neg_b_en),
    .wr_sel(wr_sel), .wr_en(wr_en), .wr_data(wr_data),
    .bus_a(bus_a), .bus_b(bus_b), .a_conflict(a_conflict), .b_conflict(b_conflict)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    a_reg_en = 0; one_a_en = 0; neg_a_en = 0;
    b_reg_en = 0; one_b_en = 0; neg_b_en = 0;
    wr_en = 0;
  endtask

  task automatic write_reg(input logic [2:0] s, input logic [DW-1:0] d);
    @(negedge clk);
    idle();
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (s != 0) model[s] = d;
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < NR; i++) begin
      @(negedge clk);
      idle();
      a_reg_en = 1; a_sel = 3'(i);
      b_reg_en = 1; b_sel = 3'(NR - 1 - i);
      #1;
      chk(tag, bus_a, model[i]);
      chk(tag, bus_b, model[NR-1-i]);
    end
  endtask

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    read_all("R10 reset value");
    rst_n = 1'b1;

    for (int k = 1; k < NR; k++)
      write_reg(3'(k), 32'h5A00_0000 ^ (32'(k) * 32'h0101_0107));

    // R2 R3: all 64 selector pairs
    for (int i = 0; i < NR; i++)
      for (int j = 0; j < NR; j++) begin
        @(negedge clk);
        idle();
        a_reg_en = 1; a_sel = 3'(i);
        b_reg_en = 1; b_sel = 3'(j);
        #1;
        chk(i == 0 ? "R1 zero entry bus A" : "R2 bus A select", bus_a, model[i]);
        chk(j == 0 ? "R1 zero entry bus B" : "R3 bus B select", bus_b, model[j]);
        chk("R9 single source flag", {31'b0, a_conflict | b_conflict}, '0);
      end

    // R6: read of a register during its own write shows the old value
    @(negedge clk);
    idle();
    wr_en = 1; wr_sel = 3'd3; wr_data = 32'hDEAD_BEEF;
    a_reg_en = 1; a_sel = 3'd3;
    #1;
    chk("R6 old value before edge", bus_a, model[3]);
    @(negedge clk);
    wr_en = 0;
    model[3] = 32'hDEAD_BEEF;
    #1;
    chk("R6 new value after edge", bus_a, model[3]);

    // R11: null destination
    write_reg(3'd0, 32'hFFFF_FFFF);
    read_all("R11 null destination");

    // R5: write enable low
    @(negedge clk);
    idle();
    wr_en = 0; wr_sel = 3'd5; wr_data = 32'h1234_5678;
    @(negedge clk);
    read_all("R5 enable low");

    // R4: each destination changes only itself
    for (int k = 1; k < NR; k++) begin
      write_reg(3'(k), ~(32'(k) << 4));
      read_all("R4 single destination");
    end

    // R7 R8 R9: all enable combinations on both buses, reg 6 selected
    for (int c = 0; c < 8; c++) begin
      logic [DW-1:0] e;
      @(negedge clk);
      idle();
      a_sel = 3'd6; b_sel = 3'd6;
      a_reg_en = c[0]; one_a_en = c[1]; neg_a_en = c[2];
      b_reg_en = c[0]; one_b_en = c[1]; neg_b_en = c[2];
      #1;
      e = (c[0] ? model[6] : '0) | (c[1] ? 32'd1 : '0) | (c[2] ? '1 : '0);
      chk(c == 0 ? "R7 idle bus A" : (c == 2 || c == 4) ? "R8 constant bus A" : "R9 bus A value", bus_a, e);
      chk(c == 0 ? "R7 idle bus B" : (c == 2 || c == 4) ? "R8 constant bus B" : "R9 bus B value", bus_b, e);
      chk("R9 conflict A", {31'b0, a_conflict}, {31'b0, (c[0] + c[1] + c[2]) > 1});
      chk("R9 conflict B", {31'b0, b_conflict}, {31'b0, (c[0] + c[1] + c[2]) > 1});
    end

    // R8: constants on one bus leave the other alone
    @(negedge clk);
    idle();
    one_a_en = 1; neg_b_en = 1;
    #1;
    chk("R8 +1 on A", bus_a, 32'd1);
    chk("R8 -1 on B", bus_b, 32'hFFFF_FFFF);

    // R10: reset in mid-run
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    for (int i = 0; i < NR; i++) model[i] = '0;
    #1;
    read_all("R10 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    write_reg(3'd7, 32'h0BAD_F00D);
    read_all("R4 write after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule